// File: doc/BRIEF.md
# Dual-Resolution Prescaled PWM Generator

This block produces pulse-width-modulated waveforms for a small number of channels, two by default. Each channel divides the system clock by a selectable power of two (2, 4, 8 or 16) to make a slow tick. The tick advances a free-running time-base counter, and the counter is compared against a programmed duty value to produce one output bit. A per-channel mode bit chooses between a full 256-count frame and a short 32-count frame. In the short mode the three upper duty bits add fractional resolution: in frame k of a repeating group of eight frames, the output stays high for one extra tick when k is below that 3-bit value.

Software-facing state is one control byte and one data byte per channel, written through a simple byte write port. Writes land in shadow registers and reach the active comparison only at a frame boundary, or at once while the channel is disabled, so a running waveform never shows a runt pulse. A per-channel enable input selects what the pin carries: the waveform, or the general-purpose pin value passed straight through. While its enable is low the channel's divider and counters are held at zero, so enabling it always starts a fresh frame.

Top module: `dual_pwm`

## Requirements
- R1: During and right after reset all shadow and active registers are zero and every `pwm_pin` bit equals the matching `gpio_in` bit.
- R2: Control bits [1:0] set the tick period in clock cycles: 00 gives 2, 01 gives 4, 10 gives 8, 11 gives 16. The counter holds its value for exactly that many cycles.
- R3: With control bit 2 clear, a frame lasts 256 ticks and the output is high while the count is below the 8-bit duty value, so it is high for duty ticks per frame.
- R4: With control bit 2 set, a frame lasts 32 ticks. The output is high while the count is below data bits [4:0], plus one tick at count equal to data bits [4:0] in frame k (k counting 0 to 7) when k is below data bits [7:5]. Over eight frames this gives 8*data[4:0] + data[7:5] high ticks.
- R5: A duty value of zero keeps the enabled output low for the whole frame.
- R6: A write to the control or data byte of a running channel has no effect on its output until the current frame ends.
- R7: While a channel's enable is low its pin carries `gpio_in`, and its divider, counter and frame index are held at zero. On the cycle the enable rises the waveform starts at count 0, so a nonzero duty gives a high pin at once.
- R8: A write addressed to one channel does not alter the waveform of any other channel.
- R9: Control bits [7:3] are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one byte per cycle |
| wr_ch | input | 1 | Channel addressed by the write (CH_W bits) |
| wr_sel | input | 1 | 0 writes the control byte, 1 writes the data (duty) byte |
| wr_data | input | 8 | Byte to write |
| ch_en | input | 2 | Per-channel enable: waveform to the pin and counters running |
| gpio_in | input | 2 | General-purpose pin values passed through while disabled |
| pwm_pin | output | 2 | Pin outputs |

## Verification
The waveform is tried with a zero duty, a mid-range 8-bit duty at the fastest divider, a small duty at the slowest divider, and a short-frame value whose upper bits are nonzero. Together these separate a wrong divider from a wrong frame length and from a missing fractional extension, because each shows a different high-cycle total over one full period. A duty rewrite in the middle of a frame, followed by cycles whose count sits between the old and new duty, tells immediate loading apart from frame-boundary loading. Cross-channel writes, control bytes with junk in the upper bits, and an enable toggled while `gpio_in` changes cover isolation, field masking and the pass-through path. A cycle-level reference model is compared with both pins on every clock.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int DATA_W  = 8;
    localparam int SHORT_W = 5;
    localparam int EXT_W   = DATA_W - SHORT_W;
    localparam int PSC_W   = 4;
    localparam int CFG_W   = 3;

    localparam logic [DATA_W-1:0] LONG_TOP  = {DATA_W{1'b1}};
    localparam logic [DATA_W-1:0] SHORT_TOP = DATA_W'((1 << SHORT_W) - 1);

    typedef struct packed {
        logic       short_mode;
        logic [1:0] div_sel;
    } pwm_cfg_t;

    function automatic pwm_cfg_t decode_ctrl(input logic [CFG_W-1:0] b);
        pwm_cfg_t r;
        r.short_mode = b[2];
        r.div_sel    = b[1:0];
        return r;
    endfunction

    function automatic logic [PSC_W-1:0] div_limit(input logic [1:0] sel);
        logic [PSC_W-1:0] r;
        case (sel)
            2'd0:    r = PSC_W'(1);
            2'd1:    r = PSC_W'(3);
            2'd2:    r = PSC_W'(7);
            default: r = PSC_W'(15);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PSC_W-1:0] lim,
    output logic             tick,
    output logic [PSC_W-1:0] psc_q
);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            psc_q <= '0;
        end else if (psc_q == lim) begin
            psc_q <= '0;
        end else begin
            psc_q <= psc_q + PSC_W'(1);
        end
    end

    assign tick = run && (psc_q == lim);

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              tick,
    input  logic              short_mode,
    output logic [DATA_W-1:0] cnt_q,
    output logic [EXT_W-1:0]  frame_q,
    output logic              wrap
);

    logic [DATA_W-1:0] top;

    assign top  = short_mode ? SHORT_TOP : LONG_TOP;
    assign wrap = tick && (cnt_q == top);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q   <= '0;
            frame_q <= '0;
        end else if (wrap) begin
            cnt_q   <= '0;
            frame_q <= frame_q + EXT_W'(1);
        end else if (tick) begin
            cnt_q   <= cnt_q + DATA_W'(1);
        end
    end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              wr_ctrl,
    input  logic              wr_duty,
    input  logic [DATA_W-1:0] wr_byte,
    output logic              wave,
    output logic [DATA_W-1:0] mon_cnt,
    output logic [PSC_W-1:0]  mon_psc,
    output logic [EXT_W-1:0]  mon_frame,
    output logic [PSC_W-1:0]  mon_lim,
    output logic              mon_short,
    output logic [DATA_W-1:0] mon_duty
);

    pwm_cfg_t          sh_cfg, act_cfg;
    logic [DATA_W-1:0] sh_duty, act_duty;
    logic              tick, wrap, load;
    logic [PSC_W-1:0]  lim, psc;
    logic [DATA_W-1:0] cnt;
    logic [EXT_W-1:0]  frame;

    // shadow copies, written from the port
    always_ff @(posedge clk) begin
        if (rst) begin
            sh_cfg  <= '0;
            sh_duty <= '0;
        end else begin
            if (wr_ctrl) sh_cfg  <= decode_ctrl(wr_byte[CFG_W-1:0]);
            if (wr_duty) sh_duty <= wr_byte;
        end
    end

    // active copies follow the shadow while idle or at a frame end
    assign load = !run || wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_cfg  <= '0;
            act_duty <= '0;
        end else if (load) begin
            act_cfg  <= sh_cfg;
            act_duty <= sh_duty;
        end
    end

    assign lim = div_limit(act_cfg.div_sel);

    pwm_prescaler u_psc (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .lim   (lim),
        .tick  (tick),
        .psc_q (psc)
    );

    pwm_timebase u_tb (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .tick       (tick),
        .short_mode (act_cfg.short_mode),
        .cnt_q      (cnt),
        .frame_q    (frame),
        .wrap       (wrap)
    );

    // comparator
    logic [SHORT_W-1:0] c_lo, d_lo;
    logic [EXT_W-1:0]   d_hi;
    logic               hi_short, hi_long;

    assign c_lo     = cnt[SHORT_W-1:0];
    assign d_lo     = act_duty[SHORT_W-1:0];
    assign d_hi     = act_duty[DATA_W-1:SHORT_W];
    assign hi_short = (c_lo < d_lo) || ((c_lo == d_lo) && (frame < d_hi));
    assign hi_long  = cnt < act_duty;
    assign wave     = act_cfg.short_mode ? hi_short : hi_long;

    assign mon_cnt   = cnt;
    assign mon_psc   = psc;
    assign mon_frame = frame;
    assign mon_lim   = lim;
    assign mon_short = act_cfg.short_mode;
    assign mon_duty  = act_duty;

endmodule

// File: rtl/dual_pwm.sv
module dual_pwm
    import pwm_pkg::*;
#(
    parameter int NCH  = 2,
    parameter int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NCH-1:0]    ch_en,
    input  logic [NCH-1:0]    gpio_in,
    output logic [NCH-1:0]    pwm_pin
);

    logic [NCH-1:0]             wave;
    logic [NCH-1:0][DATA_W-1:0] mon_cnt;
    logic [NCH-1:0][PSC_W-1:0]  mon_psc;
    logic [NCH-1:0][EXT_W-1:0]  mon_frame;
    logic [NCH-1:0][PSC_W-1:0]  mon_lim;
    logic [NCH-1:0]             mon_short;
    logic [NCH-1:0][DATA_W-1:0] mon_duty;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic hit;
        assign hit = wr_en && (wr_ch == CH_W'(i));

        pwm_channel u_ch (
            .clk       (clk),
            .rst       (rst),
            .run       (ch_en[i]),
            .wr_ctrl   (hit && !wr_sel),
            .wr_duty   (hit && wr_sel),
            .wr_byte   (wr_data),
            .wave      (wave[i]),
            .mon_cnt   (mon_cnt[i]),
            .mon_psc   (mon_psc[i]),
            .mon_frame (mon_frame[i]),
            .mon_lim   (mon_lim[i]),
            .mon_short (mon_short[i]),
            .mon_duty  (mon_duty[i])
        );

        assign pwm_pin[i] = ch_en[i] ? wave[i] : gpio_in[i];
    end

endmodule

// File: rtl/pwm_checker.sv
module pwm_checker
    import pwm_pkg::*;
#(
    parameter int NCH = 2
) (
    input logic                        clk,
    input logic                        rst,
    input logic [NCH-1:0]              ch_en,
    input logic [NCH-1:0]              wave,
    input logic [NCH-1:0][DATA_W-1:0]  mon_cnt,
    input logic [NCH-1:0][PSC_W-1:0]   mon_psc,
    input logic [NCH-1:0][EXT_W-1:0]   mon_frame,
    input logic [NCH-1:0][PSC_W-1:0]   mon_lim,
    input logic [NCH-1:0]              mon_short,
    input logic [NCH-1:0][DATA_W-1:0]  mon_duty
);

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R7: idle channel keeps its divider and counter at zero
        p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
            !ch_en[i] |=> (mon_cnt[i] == '0) && (mon_psc[i] == '0));

        // R2: count only moves on the cycle the divider reaches its limit
        p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
            (ch_en[i] && (mon_psc[i] != mon_lim[i])) |=> $stable(mon_cnt[i]));

        // R2: divider never passes its limit
        p_psc_range_r2: assert property (@(posedge clk) disable iff (rst)
            mon_psc[i] <= mon_lim[i]);

        // R4: short frames never exceed 32 counts
        p_short_range_r4: assert property (@(posedge clk) disable iff (rst)
            (ch_en[i] && mon_short[i]) |-> (mon_cnt[i] <= SHORT_TOP));

        // R4: frame index only moves together with a count restart
        p_frame_step_r4: assert property (@(posedge clk) disable iff (rst)
            !$stable(mon_frame[i]) |-> (mon_cnt[i] == '0));

        // R5: zero duty never drives the waveform high
        p_zero_duty_r5: assert property (@(posedge clk) disable iff (rst)
            (mon_duty[i] == '0) |-> !wave[i]);
    end

endmodule

bind dual_pwm pwm_checker #(.NCH(NCH)) u_pwm_chk (
    .clk       (clk),
    .rst       (rst),
    .ch_en     (ch_en),
    .wave      (wave),
    .mon_cnt   (mon_cnt),
    .mon_psc   (mon_psc),
    .mon_frame (mon_frame),
    .mon_lim   (mon_lim),
    .mon_short (mon_short),
    .mon_duty  (mon_duty)
);

// File: tb/test_dual_pwm.sv
`timescale 1ns/1ps
module test_dual_pwm;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [0:0] wr_ch = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] ch_en = 2'b00;
    logic [1:0] gpio_in = 2'b10;
    logic [1:0] pwm_pin;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dual_pwm i_dual_pwm (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_ch   (wr_ch),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .ch_en   (ch_en),
        .gpio_in (gpio_in),
        .pwm_pin (pwm_pin)
    );

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_sh_ctrl[2], m_sh_duty[2], m_ctrl[2], m_duty[2];
    int m_psc[2], m_cnt[2], m_frm[2];

    always @(posedge clk) begin
        for (int c = 0; c < 2; c++) begin
            if (rst) begin
                m_sh_ctrl[c] = 0; m_sh_duty[c] = 0; m_ctrl[c] = 0; m_duty[c] = 0;
                m_psc[c] = 0; m_cnt[c] = 0; m_frm[c] = 0;
            end else begin
                if (!ch_en[c]) begin
                    m_psc[c] = 0; m_cnt[c] = 0; m_frm[c] = 0;
                    m_ctrl[c] = m_sh_ctrl[c]; m_duty[c] = m_sh_duty[c];
                end else if (m_psc[c] == (2 << (m_ctrl[c] % 4)) - 1) begin
                    m_psc[c] = 0;
                    if (m_cnt[c] == (((m_ctrl[c] / 4) % 2 == 1) ? 31 : 255)) begin
                        m_cnt[c] = 0;
                        m_frm[c] = (m_frm[c] + 1) % 8;
                        m_ctrl[c] = m_sh_ctrl[c]; m_duty[c] = m_sh_duty[c];
                    end else begin
                        m_cnt[c]++;
                    end
                end else begin
                    m_psc[c]++;
                end
                if (wr_en && wr_ch == c) begin
                    if (wr_sel) m_sh_duty[c] = wr_data;
                    else        m_sh_ctrl[c] = wr_data % 8;   // R9: only bits [2:0]
                end
            end
        end
    end

    function automatic int model_pin(int c);
        int lo, hi;
        if (!ch_en[c]) return gpio_in[c];
        if ((m_ctrl[c] / 4) % 2 == 1) begin
            lo = m_duty[c] % 32;
            hi = m_duty[c] / 32;
            return ((m_cnt[c] < lo) || (m_cnt[c] == lo && m_frm[c] < hi)) ? 1 : 0;
        end
        return (m_cnt[c] < m_duty[c]) ? 1 : 0;
    endfunction

    always @(negedge clk) begin
        #1;
        if (!rst && !done) begin
            for (int c = 0; c < 2; c++) begin
                if (!ch_en[c])
                    check("R7 pass-through", pwm_pin[c], model_pin(c));
                else if ((m_ctrl[c] / 4) % 2 == 1)
                    check("R4 model", pwm_pin[c], model_pin(c));
                else
                    check("R3 model", pwm_pin[c], model_pin(c));
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(int ch, int sel, int val);
        wr_en = 1'b1; wr_ch = 1'(ch); wr_sel = 1'(sel); wr_data = 8'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic setup(int ch, int ctrl, int duty);
        wr(ch, 0, ctrl);
        wr(ch, 1, duty);
        @(negedge clk);
    endtask

    task automatic measure(int ch, int n, output int hi);
        hi = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (pwm_pin[ch]) hi++;
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int hi;
        repeat (4) @(negedge clk);
        // R1: pins follow gpio during reset
        check("R1 reset pin0", pwm_pin[0], 0);
        check("R1 reset pin1", pwm_pin[1], 1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", pwm_pin, 2'b10);

        // R5: enable with reset-state duty of zero
        ch_en = 2'b11;
        measure(0, 512, hi);
        check("R5 zero duty", hi, 0);
        ch_en = 2'b00;
        @(negedge clk);

        // R3 / R2: 8-bit, divide by 2, duty 100
        setup(0, 8'h00, 100);
        ch_en[0] = 1'b1;
        measure(0, 512, hi);
        check("R3 8-bit duty 100", hi, 200);
        ch_en[0] = 1'b0;

        // R2: divide by 16, duty 3
        setup(0, 8'h03, 3);
        ch_en[0] = 1'b1;
        measure(0, 4096, hi);
        check("R2 div16 duty 3", hi, 48);
        ch_en[0] = 1'b0;

        // R4: short frames, divide by 4, lo=9, hi=5
        setup(0, 8'h05, 8'hA9);
        ch_en[0] = 1'b1;
        measure(0, 1024, hi);
        check("R4 short frame extension", hi, 308);
        ch_en[0] = 1'b0;

        // R6: mid-frame duty rewrite is deferred
        setup(0, 8'h00, 10);
        ch_en[0] = 1'b1;
        repeat (50) @(negedge clk);
        wr(0, 1, 200);
        for (int k = 0; k < 10; k++) begin
            check("R6 deferred load", pwm_pin[0], 0);
            @(negedge clk);
        end
        repeat (600) @(negedge clk);
        measure(0, 512, hi);
        check("R6 new duty after boundary", hi, 400);

        // R7: disable passes gpio, re-enable starts high at once
        ch_en[0] = 1'b0;
        gpio_in[0] = 1'b1;
        #1 check("R7 gpio high", pwm_pin[0], 1);
        @(negedge clk);
        gpio_in[0] = 1'b0;
        #1 check("R7 gpio low", pwm_pin[0], 0);
        @(negedge clk);
        ch_en[0] = 1'b1;
        #1 check("R7 restart high", pwm_pin[0], 1);
        @(negedge clk);
        ch_en[0] = 1'b0;
        @(negedge clk);

        // R8: writes to channel 0 leave channel 1 untouched
        setup(1, 8'h01, 50);
        ch_en[1] = 1'b1;
        repeat (30) @(negedge clk);
        setup(0, 8'h07, 8'hFF);
        measure(1, 1024, hi);
        check("R8 channel isolation", hi, 200);
        ch_en[1] = 1'b0;

        // R9: upper control bits ignored
        setup(0, 8'hF8, 4);
        ch_en[0] = 1'b1;
        measure(0, 512, hi);
        check("R9 upper ctrl bits", hi, 8);
        ch_en[0] = 1'b0;
        @(negedge clk);

        finish_run();
    end

endmodule